// File: doc/BRIEF.md
# Pattern-Fill Memory Scrubber

The scrubber takes ownership of a byte-wide synchronous single-port memory. It first writes a known pattern into an address window. It then sweeps that window without end, reading each location and comparing it with the value it should hold. When a location disagrees, the scrubber writes the correct byte back into it and produces an error record through a valid/ready output. The record holds the address, the byte that was read, the byte that was expected, and a time tag. A counter reports how many full sweeps have been completed.

Two fill modes exist. Window mode writes 0x55 over a window that the caller chooses, for example 0x20..0xFF or the smaller 0x20..0x80. Bank mode covers a fixed region of banked registers and picks the pattern from the bank index, so that adjacent banks hold complementary bit patterns. Start and stop pulses control the engine. It never drops a record. When the record slot is full, it stalls instead.

Top module: `mem_scrubber`

## Requirements
- R1: While reset is held and after it is released, the memory port is idle (`mem_en_o`=0, `mem_we_o`=0), `rec_valid_o` is 0 and `sweeps_o` is 0.
- R2: A start pulse accepted in idle latches the window. In window mode (`bank_mode_i`=0) the engine writes 0x55 to every address from `win_lo_i` to `win_hi_i` once, in ascending order, one per cycle, beginning the cycle after the pulse. It accesses no address outside the window.
- R3: After the fill, each location is read in one cycle and compared in the next. A match moves to the next address, so a matching location takes 2 cycles. After the upper address the sweep wraps to the lower address and continues without stopping.
- R4: On a miscompare, the cycle after the compare writes the expected byte back to the same address, so the location takes 3 cycles. The next address is read in the following cycle.
- R5: An error record becomes valid the cycle after the corrective write. It carries the address, the observed byte, the expected byte and a time tag. The tag is the value, during the compare cycle, of a free-running cycle counter that is 0 in the first cycle after reset.
- R6: While `rec_valid_o`=1 and `rec_ready_i`=0, all record fields hold steady. A further miscompare stalls in its write cycle, with the memory port idle, until the slot frees. No record is lost.
- R7: `sweeps_o` is cleared when a start is accepted. It increments by one each time the sweep wraps from the upper to the lower address. The fill pass does not count.
- R8: In bank mode (`bank_mode_i`=1) the window inputs are ignored. The region is addresses 0x00..0x1F, made of 4 banks of 8 registers each, where bank = address/8. Even banks hold 0xAA and odd banks hold 0x55, for both fill and compare.
- R9: A stop pulse returns the engine to idle, and the memory port is quiet from the next cycle on.
- R10: A start pulse while the engine is active is ignored. The window and the sweep counter carry on unchanged.
- R11: A start in window mode with `win_lo_i` greater than `win_hi_i` is ignored, and the engine stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse (idle only) |
| stop_i | input | 1 | Stop pulse, has priority |
| bank_mode_i | input | 1 | 0 = window fill, 1 = banked register fill |
| win_lo_i | input | ADDR_W | Lower window address (inclusive) |
| win_hi_i | input | ADDR_W | Upper window address (inclusive) |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, one cycle after a read |
| rec_valid_o | output | 1 | Error record valid |
| rec_ready_i | input | 1 | Error record accepted |
| rec_addr_o | output | ADDR_W | Record: failing address |
| rec_obs_o | output | 8 | Record: byte read |
| rec_exp_o | output | 8 | Record: byte expected |
| rec_tag_o | output | TAG_W | Record: time tag |
| sweeps_o | output | SWEEP_W | Completed sweep count |

## Verification
All timing below is counted from the clock edge that samples the start pulse, with the window holding N locations:

- The first fill write appears in the cycle after that edge.
- The first read of the lower address appears N cycles after the first fill write.
- A clean first sweep raises `sweeps_o` exactly 2N cycles after that first read.

For a location that is corrupted before its read:

- The corrective write appears two cycles after the read.
- The record becomes valid three cycles after the read.
- The record's tag equals the bench's own cycle count at the compare cycle.

The bench samples every output 2 ns after the rising edge. It also makes each corruption at a known point of the sweep, so each result is checked in exactly the cycle it is due. Under back-pressure it checks the exact cycle in which the stalled write resumes.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] PAT_ODD  = 8'h55;
  localparam logic [BYTE_W-1:0] PAT_EVEN = 8'hAA;

  typedef enum logic [2:0] {ST_IDLE, ST_FILL, ST_READ, ST_CMP, ST_FIX} state_t;

  // expected byte: window mode always PAT_ODD, bank mode alternates by bank parity
  function automatic logic [BYTE_W-1:0] pattern_for(input logic bank_mode, input logic odd_bank);
    if (!bank_mode) return PAT_ODD;
    return odd_bank ? PAT_ODD : PAT_EVEN;
  endfunction
endpackage

// File: rtl/scrub_ctr.sv
module scrub_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= '0;
    else if (clr_i) q_o <= '0;
    else if (inc_i) q_o <= q_o + 1'b1;
  end
endmodule

// File: rtl/scrub_rec.sv
module scrub_rec import scrub_pkg::*; #(
  parameter int ADDR_W = 8,
  parameter int TAG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snap_i,
  input  logic [BYTE_W-1:0] obs_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] exp_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] obs_o,
  output logic [BYTE_W-1:0] exp_o,
  output logic [TAG_W-1:0]  tag_o
);
  logic [BYTE_W-1:0] snap_obs_q;
  logic [TAG_W-1:0]  snap_tag_q;

  // snapshot at the compare cycle, published at the write cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap_obs_q <= '0;
      snap_tag_q <= '0;
    end else if (snap_i) begin
      snap_obs_q <= obs_i;
      snap_tag_q <= tag_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      obs_o   <= '0;
      exp_o   <= '0;
      tag_o   <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      addr_o  <= addr_i;
      obs_o   <= snap_obs_q;
      exp_o   <= exp_i;
      tag_o   <= snap_tag_q;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  a_r6_hold_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(obs_o)
                               && $stable(exp_o) && $stable(tag_o)));

  a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (!valid_o || ready_i));
endmodule

// File: rtl/scrub_seq.sv
module scrub_seq import scrub_pkg::*; #(
  parameter int ADDR_W  = 8,
  parameter int BANK_SH = 3,
  parameter int BANK_HI = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              bank_mode_i,
  input  logic [ADDR_W-1:0] lo_i,
  input  logic [ADDR_W-1:0] hi_i,
  input  logic [BYTE_W-1:0] rdata_i,
  input  logic              slot_free_i,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  output logic [BYTE_W-1:0] exp_o,
  output logic              miss_o,
  output logic              load_o,
  output logic              wrap_o,
  output logic              clear_o
);
  localparam logic [ADDR_W-1:0] REGION_HI = ADDR_W'(BANK_HI);

  state_t            state_q;
  logic              mode_q;
  logic [ADDR_W-1:0] lo_q, hi_q, addr_q;
  logic              last_w, hit_w, advance_w, accept_w;

  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] a,
                                             input logic wrap_now,
                                             input logic [ADDR_W-1:0] base);
    return wrap_now ? base : ADDR_W'(a + 1'b1);
  endfunction

  assign last_w    = (addr_q == hi_q);
  assign exp_o     = pattern_for(mode_q, addr_q[BANK_SH]);
  assign hit_w     = (state_q == ST_CMP) && (rdata_i == exp_o);
  assign miss_o    = (state_q == ST_CMP) && (rdata_i != exp_o);
  assign load_o    = (state_q == ST_FIX) && slot_free_i;
  assign advance_w = hit_w || load_o;
  assign wrap_o    = advance_w && last_w;
  assign accept_w  = (state_q == ST_IDLE) && start_i && !stop_i
                     && (bank_mode_i || (lo_i <= hi_i));
  assign clear_o   = accept_w;

  always_comb begin
    mem_en_o    = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = addr_q;
    mem_wdata_o = exp_o;
    unique case (state_q)
      ST_FILL: begin mem_en_o = 1'b1; mem_we_o = 1'b1; end
      ST_READ: mem_en_o = 1'b1;
      ST_FIX:  begin mem_en_o = slot_free_i; mem_we_o = slot_free_i; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
      addr_q  <= '0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_w) begin
          state_q <= ST_FILL;
          mode_q  <= bank_mode_i;
          lo_q    <= bank_mode_i ? '0 : lo_i;
          hi_q    <= bank_mode_i ? REGION_HI : hi_i;
          addr_q  <= bank_mode_i ? '0 : lo_i;
        end
        ST_FILL: begin
          addr_q <= step(addr_q, last_w, lo_q);
          if (last_w) state_q <= ST_READ;
        end
        ST_READ: state_q <= ST_CMP;
        ST_CMP: begin
          if (hit_w) begin
            addr_q  <= step(addr_q, last_w, lo_q);
            state_q <= ST_READ;
          end else begin
            state_q <= ST_FIX;
          end
        end
        ST_FIX: if (slot_free_i) begin
          addr_q  <= step(addr_q, last_w, lo_q);
          state_q <= ST_READ;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r2_write_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (mem_addr_o >= lo_q && mem_addr_o <= hi_q));

  a_r3_hit_reads_next: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_w && !stop_i) |=> (mem_en_o && !mem_we_o &&
      mem_addr_o == ($past(last_w) ? lo_q : ADDR_W'($past(mem_addr_o) + 1'b1))));

  a_r4_miss_fixes_same: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_o && !stop_i) |=> (state_q == ST_FIX && $stable(mem_addr_o)));

  a_r9_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> !mem_en_o);
endmodule

// File: rtl/mem_scrubber.sv
module mem_scrubber import scrub_pkg::*; #(
  parameter int ADDR_W    = 8,
  parameter int BANKS     = 4,
  parameter int BANK_REGS = 8,
  parameter int TAG_W     = 16,
  parameter int SWEEP_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               bank_mode_i,
  input  logic [ADDR_W-1:0]  win_lo_i,
  input  logic [ADDR_W-1:0]  win_hi_i,
  output logic               mem_en_o,
  output logic               mem_we_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [BYTE_W-1:0]  mem_wdata_o,
  input  logic [BYTE_W-1:0]  mem_rdata_i,
  output logic               rec_valid_o,
  input  logic               rec_ready_i,
  output logic [ADDR_W-1:0]  rec_addr_o,
  output logic [BYTE_W-1:0]  rec_obs_o,
  output logic [BYTE_W-1:0]  rec_exp_o,
  output logic [TAG_W-1:0]   rec_tag_o,
  output logic [SWEEP_W-1:0] sweeps_o
);
  localparam int BANK_SH   = $clog2(BANK_REGS);
  localparam int BANK_SPAN = BANKS * BANK_REGS;
  localparam int BANK_HI   = BANK_SPAN - 1;

  logic [BYTE_W-1:0] exp_w;
  logic [TAG_W-1:0]  tag_w;
  logic miss_w, load_w, wrap_w, clear_w, slot_free_w;

  assign slot_free_w = !rec_valid_o || rec_ready_i;

  scrub_seq #(.ADDR_W(ADDR_W), .BANK_SH(BANK_SH), .BANK_HI(BANK_HI)) seq_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .bank_mode_i(bank_mode_i), .lo_i(win_lo_i), .hi_i(win_hi_i),
    .rdata_i(mem_rdata_i), .slot_free_i(slot_free_w),
    .mem_en_o(mem_en_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .exp_o(exp_w), .miss_o(miss_w),
    .load_o(load_w), .wrap_o(wrap_w), .clear_o(clear_w)
  );

  scrub_ctr #(.W(TAG_W)) tag_i (
    .clk(clk), .rst_n(rst_n), .clr_i(1'b0), .inc_i(1'b1), .q_o(tag_w)
  );

  scrub_ctr #(.W(SWEEP_W)) sweep_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clear_w), .inc_i(wrap_w), .q_o(sweeps_o)
  );

  scrub_rec #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) rec_i (
    .clk(clk), .rst_n(rst_n), .snap_i(miss_w), .obs_i(mem_rdata_i), .tag_i(tag_w),
    .load_i(load_w), .addr_i(mem_addr_o), .exp_i(exp_w), .ready_i(rec_ready_i),
    .valid_o(rec_valid_o), .addr_o(rec_addr_o), .obs_o(rec_obs_o),
    .exp_o(rec_exp_o), .tag_o(rec_tag_o)
  );

  a_r7_sweep_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (sweeps_o != $past(sweeps_o)) |-> ($past(wrap_w) || $past(clear_w)));

  a_r5_record_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rec_valid_o) |-> $past(mem_we_o));
endmodule

// File: tb/mem_scrubber_tb_top.sv
module mem_scrubber_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start, stop, bank_mode, rec_ready;
  logic [7:0] win_lo, win_hi;
  logic mem_en, mem_we, rec_valid;
  logic [7:0] mem_addr, mem_wdata, mem_rdata, rec_addr, rec_obs, rec_exp;
  logic [15:0] rec_tag, sweeps;

  mem_scrubber dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop), .bank_mode_i(bank_mode),
    .win_lo_i(win_lo), .win_hi_i(win_hi), .mem_en_o(mem_en), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .rec_valid_o(rec_valid), .rec_ready_i(rec_ready), .rec_addr_o(rec_addr),
    .rec_obs_o(rec_obs), .rec_exp_o(rec_exp), .rec_tag_o(rec_tag), .sweeps_o(sweeps)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] mem [256];
  int mon_lo = 0, mon_hi = 255, oor = 0, fill_bad = 0;
  int rq_addr[$], rq_obs[$], rq_tag[$];

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;
    if (mem_en) begin
      mem_rdata <= mem[mem_addr];
      if (mem_we) mem[mem_addr] = mem_wdata;
    end
  end

  always @(negedge clk) begin
    if (mem_en && (int'(mem_addr) < mon_lo || int'(mem_addr) > mon_hi)) oor = oor + 1;
    if (rec_valid && rec_ready) begin
      rq_addr.push_back(int'(rec_addr));
      rq_obs.push_back(int'(rec_obs));
      rq_tag.push_back(int'(rec_tag));
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  function automatic int pat(input bit bank, input int a);
    if (!bank) return 'h55;
    return ((a / 8) % 2 == 1) ? 'h55 : 'hAA;
  endfunction

  // start, check fill order/data, first read, first sweep timing; ends at READ lo of sweep 2
  task automatic run_fill(input int dlo, input int dhi, input bit bank);
    int elo, ehi, n, bad;
    elo = bank ? 0 : dlo;
    ehi = bank ? 31 : dhi;
    n = ehi - elo + 1;
    for (int a = elo; a <= ehi; a++) mem[a] = 8'h00;
    mon_lo = elo; mon_hi = ehi; oor = 0;
    win_lo = 8'(dlo); win_hi = 8'(dhi); bank_mode = bank; start = 1'b1;
    tick();
    start = 1'b0;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      if (!(mem_en && mem_we && int'(mem_addr) == elo + i && int'(mem_wdata) == pat(bank, elo + i)))
        bad++;
      tick();
    end
    chk(bad == 0, bank ? "R8 fill order/data" : "R2 fill order/data", bad, 0);
    chk(mem_en && !mem_we && int'(mem_addr) == elo, "R3 first read at lower address",
        int'(mem_addr), elo);
    bad = 0;
    for (int a = elo; a <= ehi; a++) if (int'(mem[a]) != pat(bank, a)) bad++;
    chk(bad == 0, bank ? "R8 bank contents" : "R2 window contents", bad, 0);
    ticks(2 * n - 1);
    chk(sweeps == 0, "R7 no count before wrap", int'(sweeps), 0);
    tick();
    chk(sweeps == 1, "R7 count at wrap (R3 2 cycles/location)", int'(sweeps), 1);
    chk(mem_en && !mem_we && int'(mem_addr) == elo, "R3 sweep repeats", int'(mem_addr), elo);
    chk(oor == 0 && !rec_valid, "R2 no access outside window", oor, 0);
  endtask

  task automatic stop_run();
    stop = 1'b1;
    tick();
    stop = 1'b0;
    chk(!mem_en, "R9 port quiet after stop", int'(mem_en), 0);
    ticks(2);
    chk(!mem_en, "R9 stays idle", int'(mem_en), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    checks++; errors++;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c0, t0, nb, bad;
    for (int a = 0; a < 256; a++) mem[a] = 8'h00;
    rst_n = 1'b0; start = 1'b0; stop = 1'b0; bank_mode = 1'b0; rec_ready = 1'b1;
    win_lo = 8'h00; win_hi = 8'h00;
    ticks(3);
    chk(!mem_en && !mem_we && !rec_valid && sweeps == 0, "R1 reset state", int'(mem_en), 0);
    rst_n = 1'b1;
    ticks(3);
    chk(!mem_en && !rec_valid && sweeps == 0, "R1 idle after reset", int'(mem_en), 0);

    // small window, then miscompare with exact timing
    run_fill('h20, 'h27, 1'b0);
    c0 = cyc;
    mem[8'h24] = 8'h12;
    ticks(10);
    chk(mem_we && mem_addr == 8'h24 && mem_wdata == 8'h55, "R4 rewrite cycle",
        int'(mem_addr), 'h24);
    chk(!rec_valid, "R5 record not before write", int'(rec_valid), 0);
    tick();
    chk(rec_valid && rec_addr == 8'h24, "R5 record address", int'(rec_addr), 'h24);
    chk(rec_obs == 8'h12 && rec_exp == 8'h55, "R5 record data", int'(rec_obs), 'h12);
    chk(int'(rec_tag) == c0 + 9, "R5 record tag", int'(rec_tag), c0 + 9);
    chk(mem[8'h24] == 8'h55, "R4 location repaired", int'(mem[8'h24]), 'h55);
    chk(mem_en && !mem_we && mem_addr == 8'h25, "R4 3 cycles then next", int'(mem_addr), 'h25);
    ticks(6);
    chk(sweeps == 2 && mem_en && mem_addr == 8'h20, "R7 second wrap", int'(sweeps), 2);

    // back-pressure
    t0 = cyc;
    nb = rq_addr.size();
    mem[8'h21] = 8'hF0;
    mem[8'h23] = 8'h0F;
    rec_ready = 1'b0;
    ticks(12);
    chk(rec_valid && rec_addr == 8'h21 && rec_obs == 8'hF0, "R6 first record held",
        int'(rec_addr), 'h21);
    chk(int'(rec_tag) == t0 + 3, "R6 held tag", int'(rec_tag), t0 + 3);
    chk(!mem_en, "R6 stalled write", int'(mem_en), 0);
    chk(mem[8'h23] == 8'h0F, "R6 no write while stalled", int'(mem[8'h23]), 'h0F);
    rec_ready = 1'b1;
    tick();
    chk(rec_valid && rec_addr == 8'h23 && rec_obs == 8'h0F, "R6 second record", int'(rec_addr), 'h23);
    chk(int'(rec_tag) == t0 + 8, "R6 second tag", int'(rec_tag), t0 + 8);
    chk(mem[8'h23] == 8'h55, "R6 write after release", int'(mem[8'h23]), 'h55);
    chk(mem_en && !mem_we && mem_addr == 8'h24, "R6 sweep resumes", int'(mem_addr), 'h24);
    tick();
    chk(rq_addr.size() == nb + 2, "R6 no record lost", rq_addr.size(), nb + 2);
    if (rq_addr.size() == nb + 2)
      chk(rq_addr[nb] == 'h21 && rq_addr[nb+1] == 'h23 && rq_obs[nb+1] == 'h0F,
          "R6 record order", rq_addr[nb], 'h21);
    stop_run();

    // bank mode, window inputs deliberately inverted garbage
    run_fill('h50, 'h10, 1'b1);
    c0 = cyc;
    mem[8'h13] = 8'h55;
    ticks(41);
    chk(rec_valid && rec_addr == 8'h13 && rec_obs == 8'h55 && rec_exp == 8'hAA,
        "R8 bank record", int'(rec_exp), 'hAA);
    chk(int'(rec_tag) == c0 + 39, "R8 bank tag (R5)", int'(rec_tag), c0 + 39);
    chk(mem[8'h13] == 8'hAA, "R8 bank repair", int'(mem[8'h13]), 'hAA);
    stop_run();

    // inverted window rejected
    win_lo = 8'h30; win_hi = 8'h2F; bank_mode = 1'b0; start = 1'b1;
    tick();
    start = 1'b0;
    bad = 0;
    for (int i = 0; i < 6; i++) begin
      if (mem_en) bad++;
      tick();
    end
    chk(bad == 0 && sweeps == 1, "R11 inverted window ignored", bad, 0);

    // start while active
    run_fill('h40, 'h43, 1'b0);
    win_lo = 8'h80; win_hi = 8'h90; start = 1'b1;
    tick();
    start = 1'b0;
    ticks(39);
    chk(oor == 0, "R10 window kept", oor, 0);
    chk(sweeps == 6, "R10 counter not cleared", int'(sweeps), 6);
    stop_run();

    // full and reduced windows
    run_fill('h20, 'hFF, 1'b0);
    stop_run();
    run_fill('h20, 'h80, 1'b0);
    stop_run();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule